// File: doc/BRIEF.md
# H4 Serial Packet Deframer

This block sits behind a serial receiver that delivers one byte at a time in the H4 transport framing. It reads the leading type byte of each packet and looks up how many header bytes follow for that type. Once the header is complete, it takes the payload length from the header and counts off the payload. Every byte of an accepted packet is forwarded one clock later on a byte-stream output. Each output byte carries the packet's type code, and the first and last bytes of the packet are marked, so the consumer never has to parse lengths itself.

Besides the usual command, ACL and SCO types, the block handles two link-management types. One is a negotiation packet that carries its own header length. The other is a fixed-size keep-alive packet. The block also rounds the parameter length of one vendor command up to an even value. Event packets are not expected from this direction. They are flagged as bad and consumed silently so that framing stays aligned. Type bytes that are not recognised are flagged and discarded one at a time. A packet whose total length exceeds the downstream buffer size raises an overflow flag but is still delimited correctly. There is no flow control: the input strobe may idle between bytes, and the output follows with a fixed one-cycle delay.

Top module: `h4_deframer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is lowered, `outValid`, `outSop`, `outEop`, `badPkt` and `overflow` are 0. A reset in the middle of a packet discards it, and the next byte is treated as a type byte.
- R2: A type byte of 1 (command), 2 (ACL), 3 (SCO), 6 (negotiation) or 7 (keep-alive) is forwarded with `outSop`=1. Every forwarded byte of that packet appears on `outData` one cycle after it was sampled, with `outType` equal to the low three bits of the type byte. Idle input cycles produce no output and do not disturb the count.
- R3: The header after the type byte is 3 bytes for command, 4 for ACL, 3 for SCO and 3 for keep-alive. For negotiation, the first header byte N is followed by N more header bytes. Negotiation and keep-alive packets have no payload, so `outEop` marks their last header byte.
- R4: Command payload length is the third header byte. When header bytes one and two are 0x00 and 0xFC (opcode 0xFC00, little-endian), an odd length is rounded up by one. A zero length puts `outEop` on the third header byte.
- R5: ACL payload length is header byte three (low) and header byte four (high). SCO payload length is header byte three. `outEop` marks the last payload byte, or the last header byte when the length is zero.
- R6: A type byte of 4 (event) pulses `badPkt` one cycle later. The event's 2-byte header and its payload (length in header byte two) are consumed with `outValid`=0.
- R7: Any other type byte pulses `badPkt` one cycle later and is dropped; the next input byte is again treated as a type byte.
- R8: The input byte that follows the end of a packet is a type byte, with no gap required.
- R9: When 1 + header length + payload length exceeds `MAX_PKT` (default 4096), `overflow` pulses on the output cycle of the last header byte. The packet is still forwarded and ended at its computed length; a total of exactly `MAX_PKT` does not flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte strobe |
| inData | input | 8 | Input byte |
| outValid | output | 1 | Forwarded byte strobe |
| outData | output | 8 | Forwarded byte |
| outType | output | 3 | Type code of the current packet |
| outSop | output | 1 | First byte of packet |
| outEop | output | 1 | Last byte of packet |
| badPkt | output | 1 | Event or unknown type seen |
| overflow | output | 1 | Packet exceeds MAX_PKT bytes |

## Verification
A wrong phase or remaining-count register shows up within one packet. `outEop` lands early or late, and the next packet's type byte is then either forwarded as body data or misread as a type byte, which breaks the start/end pairing at once. A corrupted header capture shows up as a wrong payload length, visible at that packet's end marker. The vector table chains every type back to back, so a single framing slip propagates into every later expected value. Long ACL packets on both sides of `MAX_PKT` test the overflow comparison at its exact edge.

// File: rtl/h4_deframer_pkg.sv
package h4_deframer_pkg;

  localparam logic [7:0] TY_CMD   = 8'd1;
  localparam logic [7:0] TY_ACL   = 8'd2;
  localparam logic [7:0] TY_SCO   = 8'd3;
  localparam logic [7:0] TY_EVT   = 8'd4;
  localparam logic [7:0] TY_NEG   = 8'd6;
  localparam logic [7:0] TY_ALIVE = 8'd7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_PAY  = 2'd2
  } phase_t;

  typedef struct packed {
    logic takeType;
    logic takeHdr;
    logic takePay;
    logic emit;
    logic sop;
    logic eop;
    logic flagBad;
    logic checkLen;
  } strobe_t;

  function automatic logic isKnownType(input logic [7:0] t);
    return (t == TY_CMD) || (t == TY_ACL) || (t == TY_SCO) ||
           (t == TY_EVT) || (t == TY_NEG) || (t == TY_ALIVE);
  endfunction

  // Header bytes following the type byte; negotiation starts at 1 and is
  // widened once its first header byte is known.
  function automatic logic [2:0] baseHdrLen(input logic [7:0] t);
    case (t)
      TY_CMD:   return 3'd3;
      TY_ACL:   return 3'd4;
      TY_SCO:   return 3'd3;
      TY_EVT:   return 3'd2;
      TY_ALIVE: return 3'd3;
      default:  return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/h4_ctrl.sv
module h4_ctrl
  import h4_deframer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    typeKnown,
  input  logic    typeEvent,
  input  logic    hdrLast,
  input  logic    payZero,
  input  logic    payLast,
  input  logic    dropping,
  output strobe_t st
);

  phase_t phase, phaseNext;

  always_comb begin
    st        = '0;
    phaseNext = phase;
    if (inValid) begin
      case (phase)
        PH_IDLE: begin
          if (!typeKnown) begin
            st.flagBad = 1'b1;
          end else begin
            st.takeType = 1'b1;
            st.flagBad  = typeEvent;
            st.emit     = !typeEvent;
            st.sop      = !typeEvent;
            phaseNext   = PH_HDR;
          end
        end
        PH_HDR: begin
          st.takeHdr = 1'b1;
          st.emit    = !dropping;
          if (hdrLast) begin
            st.checkLen = 1'b1;
            if (payZero) begin
              st.eop    = 1'b1;
              phaseNext = PH_IDLE;
            end else begin
              phaseNext = PH_PAY;
            end
          end
        end
        PH_PAY: begin
          st.takePay = 1'b1;
          st.emit    = !dropping;
          if (payLast) begin
            st.eop    = 1'b1;
            phaseNext = PH_IDLE;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

endmodule

// File: rtl/h4_datapath.sv
module h4_datapath
  import h4_deframer_pkg::*;
#(
  parameter int MAX_PKT = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] inData,
  input  strobe_t    st,
  output logic       typeKnown,
  output logic       typeEvent,
  output logic       hdrLast,
  output logic       payZero,
  output logic       payLast,
  output logic       dropping,
  output logic       outValid,
  output logic [7:0] outData,
  output logic [2:0] outType,
  output logic       outSop,
  output logic       outEop,
  output logic       badPkt,
  output logic       overflow
);

  localparam int HDR_KEEP = 4;
  localparam int HDR_MAX  = 256;
  localparam int IDX_W    = $clog2(HDR_MAX + 1);
  localparam int LEFT_W   = 16;
  localparam int TOT_W    = LEFT_W + 2;

  logic [2:0]        typeReg;
  logic              dropReg;
  logic [IDX_W-1:0]  hdrIdx;
  logic [LEFT_W-1:0] left;
  logic [LEFT_W-1:0] leftAfter;
  logic [LEFT_W-1:0] payLen;
  logic [TOT_W-1:0]  totLen;
  logic              overLimit;
  logic [7:0]        hdrBuf [HDR_KEEP];

  assign typeKnown = isKnownType(inData);
  assign typeEvent = (inData == TY_EVT);
  assign dropping  = dropReg;
  assign payLast   = (left == LEFT_W'(1));

  always_comb begin
    if (typeReg == TY_NEG[2:0] && hdrIdx == '0) leftAfter = LEFT_W'(inData);
    else                                        leftAfter = left - 1'b1;
  end
  assign hdrLast = (leftAfter == '0);

  always_comb begin
    case (typeReg)
      TY_CMD[2:0]: begin
        payLen = LEFT_W'(inData);
        if (hdrBuf[1] == 8'hFC && hdrBuf[0] == 8'h00)
          payLen = LEFT_W'(inData) + LEFT_W'(inData[0]);
      end
      TY_ACL[2:0]: payLen = {inData, hdrBuf[2]};
      TY_SCO[2:0]: payLen = LEFT_W'(inData);
      TY_EVT[2:0]: payLen = LEFT_W'(inData);
      default:     payLen = '0;
    endcase
  end
  assign payZero = (payLen == '0);

  assign totLen    = TOT_W'(hdrIdx) + TOT_W'(2) + TOT_W'(payLen);
  assign overLimit = (totLen > TOT_W'(MAX_PKT));

  for (genvar i = 0; i < HDR_KEEP; i++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (rst)                                        hdrBuf[i] <= '0;
      else if (st.takeHdr && hdrIdx == IDX_W'(i))     hdrBuf[i] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      typeReg <= '0;
      dropReg <= 1'b0;
      hdrIdx  <= '0;
      left    <= '0;
    end else if (st.takeType) begin
      typeReg <= inData[2:0];
      dropReg <= (inData == TY_EVT);
      hdrIdx  <= '0;
      left    <= LEFT_W'(baseHdrLen(inData));
    end else if (st.takeHdr) begin
      hdrIdx  <= hdrIdx + 1'b1;
      left    <= hdrLast ? payLen : leftAfter;
    end else if (st.takePay) begin
      left    <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
      outType  <= '0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      badPkt   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      outValid <= st.emit;
      outData  <= inData;
      outType  <= st.takeType ? inData[2:0] : typeReg;
      outSop   <= st.sop & st.emit;
      outEop   <= st.eop & st.emit;
      badPkt   <= st.flagBad;
      overflow <= st.checkLen & overLimit;
    end
  end

endmodule

// File: rtl/h4_deframer.sv
module h4_deframer
  import h4_deframer_pkg::*;
#(
  parameter int MAX_PKT = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       outValid,
  output logic [7:0] outData,
  output logic [2:0] outType,
  output logic       outSop,
  output logic       outEop,
  output logic       badPkt,
  output logic       overflow
);

  strobe_t st;
  logic typeKnown, typeEvent, hdrLast, payZero, payLast, dropping;

  h4_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .typeKnown (typeKnown),
    .typeEvent (typeEvent),
    .hdrLast   (hdrLast),
    .payZero   (payZero),
    .payLast   (payLast),
    .dropping  (dropping),
    .st        (st)
  );

  h4_datapath #(.MAX_PKT(MAX_PKT)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .inData    (inData),
    .st        (st),
    .typeKnown (typeKnown),
    .typeEvent (typeEvent),
    .hdrLast   (hdrLast),
    .payZero   (payZero),
    .payLast   (payLast),
    .dropping  (dropping),
    .outValid  (outValid),
    .outData   (outData),
    .outType   (outType),
    .outSop    (outSop),
    .outEop    (outEop),
    .badPkt    (badPkt),
    .overflow  (overflow)
  );

endmodule

// File: rtl/h4_deframer_chk.sv
module h4_deframer_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       outValid,
  input logic [7:0] outData,
  input logic [2:0] outType,
  input logic       outSop,
  input logic       outEop,
  input logic       badPkt,
  input logic       overflow
);

  logic       openPkt;
  logic [2:0] heldType;

  always_ff @(posedge clk) begin
    if (rst) begin
      openPkt  <= 1'b0;
      heldType <= '0;
    end else if (outValid) begin
      openPkt <= !outEop;
      if (outSop) heldType <= outType;
    end
  end

  AST_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(inValid) && outData == $past(inData))); // R2
  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outSop) |-> (outType == heldType)); // R2
  AST_SOP_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (outValid && outSop) |-> !openPkt); // R8
  AST_BODY_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outSop) |-> openPkt); // R3
  AST_EOP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    outEop |-> (outValid && !outSop)); // R5
  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
    badPkt |-> !outValid); // R6
  AST_OVF_ON_HEADER: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !outSop); // R9

endmodule

bind h4_deframer h4_deframer_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
  .outValid(outValid), .outData(outData), .outType(outType),
  .outSop(outSop), .outEop(outEop), .badPkt(badPkt), .overflow(overflow)
);

// File: tb/sim_h4_deframer.sv
`timescale 1ns/1ps
module sim_h4_deframer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       outValid;
  logic [7:0] outData;
  logic [2:0] outType;
  logic       outSop, outEop, badPkt, overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  h4_deframer u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData), .outType(outType),
    .outSop(outSop), .outEop(outEop), .badPkt(badPkt), .overflow(overflow)
  );

  // entry = {data, V, S, E, B, O, type, req}
  localparam int N = 58;
  localparam logic [19:0] TBL [N] = '{
    // R4 plain command, length 2
    {8'h01, 5'b11000, 3'd1, 4'd4}, {8'h03, 5'b10000, 3'd1, 4'd4},
    {8'h0C, 5'b10000, 3'd1, 4'd4}, {8'h02, 5'b10000, 3'd1, 4'd4},
    {8'hAA, 5'b10000, 3'd1, 4'd4}, {8'hBB, 5'b10100, 3'd1, 4'd4},
    // R4 opcode 0xFC00, length 3 rounded to 4
    {8'h01, 5'b11000, 3'd1, 4'd4}, {8'h00, 5'b10000, 3'd1, 4'd4},
    {8'hFC, 5'b10000, 3'd1, 4'd4}, {8'h03, 5'b10000, 3'd1, 4'd4},
    {8'h11, 5'b10000, 3'd1, 4'd4}, {8'h12, 5'b10000, 3'd1, 4'd4},
    {8'h13, 5'b10000, 3'd1, 4'd4}, {8'h14, 5'b10100, 3'd1, 4'd4},
    // R5 ACL length 2
    {8'h02, 5'b11000, 3'd2, 4'd5}, {8'h01, 5'b10000, 3'd2, 4'd5},
    {8'h00, 5'b10000, 3'd2, 4'd5}, {8'h02, 5'b10000, 3'd2, 4'd5},
    {8'h00, 5'b10000, 3'd2, 4'd5}, {8'hD0, 5'b10000, 3'd2, 4'd5},
    {8'hD1, 5'b10100, 3'd2, 4'd5},
    // R5 SCO length 1
    {8'h03, 5'b11000, 3'd3, 4'd5}, {8'h05, 5'b10000, 3'd3, 4'd5},
    {8'h00, 5'b10000, 3'd3, 4'd5}, {8'h01, 5'b10000, 3'd3, 4'd5},
    {8'hE0, 5'b10100, 3'd3, 4'd5},
    // R6 event, length 1, swallowed
    {8'h04, 5'b00010, 3'd0, 4'd6}, {8'h0E, 5'b00000, 3'd0, 4'd6},
    {8'h01, 5'b00000, 3'd0, 4'd6}, {8'h99, 5'b00000, 3'd0, 4'd6},
    // R7 unknown types 5 and 0
    {8'h05, 5'b00010, 3'd0, 4'd7}, {8'h00, 5'b00010, 3'd0, 4'd7},
    // R3 negotiation, N=2
    {8'h06, 5'b11000, 3'd6, 4'd3}, {8'h02, 5'b10000, 3'd6, 4'd3},
    {8'h5A, 5'b10000, 3'd6, 4'd3}, {8'hA5, 5'b10100, 3'd6, 4'd3},
    // R3 negotiation, N=0
    {8'h06, 5'b11000, 3'd6, 4'd3}, {8'h00, 5'b10100, 3'd6, 4'd3},
    // R3 keep-alive
    {8'h07, 5'b11000, 3'd7, 4'd3}, {8'h00, 5'b10000, 3'd7, 4'd3},
    {8'h55, 5'b10000, 3'd7, 4'd3}, {8'h00, 5'b10100, 3'd7, 4'd3},
    // R4 command, length 0
    {8'h01, 5'b11000, 3'd1, 4'd4}, {8'h03, 5'b10000, 3'd1, 4'd4},
    {8'h0C, 5'b10000, 3'd1, 4'd4}, {8'h00, 5'b10100, 3'd1, 4'd4},
    // R4 opcode 0xFC00, length 0 stays 0
    {8'h01, 5'b11000, 3'd1, 4'd4}, {8'h00, 5'b10000, 3'd1, 4'd4},
    {8'hFC, 5'b10000, 3'd1, 4'd4}, {8'h00, 5'b10100, 3'd1, 4'd4},
    // R8 event with no payload, then ACL with zero length back to back
    {8'h04, 5'b00010, 3'd0, 4'd8}, {8'h0E, 5'b00000, 3'd0, 4'd8},
    {8'h00, 5'b00000, 3'd0, 4'd8}, {8'h02, 5'b11000, 3'd2, 4'd8},
    {8'h01, 5'b10000, 3'd2, 4'd8}, {8'h00, 5'b10000, 3'd2, 4'd8},
    {8'h00, 5'b10000, 3'd2, 4'd8}, {8'h00, 5'b10100, 3'd2, 4'd8}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d);
    inValid = v;
    inData  = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] outWord(input logic [7:0] expData, input logic [2:0] expType);
    return {outValid ? outData : expData, outValid, outSop, outEop, badPkt, overflow,
            outValid ? outType : expType};
  endfunction

  task automatic longAcl(input int dlen, input bit expOvf);
    int early = 0;
    step(1'b1, 8'h02); step(1'b1, 8'h00); step(1'b1, 8'h00);
    step(1'b1, dlen[7:0]);
    step(1'b1, dlen[15:8]);
    check(overflow == expOvf && outValid && !outEop, "R9 overflow at last header byte",
          {overflow, outEop}, {expOvf, 1'b0});
    for (int k = 0; k < dlen - 1; k++) begin
      step(1'b1, k[7:0]);
      if (outEop || overflow || !outValid) early++;
    end
    step(1'b1, 8'hEE);
    check(early == 0 && outEop && outValid && outData == 8'hEE, "R9 long packet end",
          {early, outEop}, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs quiet during reset
    check({outValid, outSop, outEop, badPkt, overflow} == 5'b0, "R1 reset outputs",
          {outValid, outSop, outEop, badPkt, overflow}, 0);
    rst = 1'b0;
    step(1'b0, 8'h00);
    check({outValid, outSop, outEop, badPkt, overflow} == 5'b0, "R1 after release",
          {outValid, outSop, outEop, badPkt, overflow}, 0);

    // table walk
    for (int i = 0; i < N; i++) begin
      logic [15:0] expW;
      step(1'b1, TBL[i][19:12]);
      expW = TBL[i][19:4];
      check(outWord(TBL[i][19:12], TBL[i][6:4]) == expW,
            $sformatf("R%0d vector %0d", TBL[i][3:0], i),
            outWord(TBL[i][19:12], TBL[i][6:4]), expW);
    end

    // R2 idle gaps inside a keep-alive packet
    step(1'b1, 8'h07);
    check(outValid && outSop && outType == 3'd7, "R2 gap start", {outValid, outSop, outType}, 5'b11111);
    step(1'b0, 8'h33);
    check(!outValid, "R2 idle gives no output", outValid, 0);
    step(1'b1, 8'h00);
    step(1'b0, 8'h00);
    step(1'b1, 8'h55);
    check(outValid && !outEop && outData == 8'h55, "R2 gap body", {outValid, outEop}, 2'b10);
    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    step(1'b1, 8'h00);
    check(outValid && outEop && outType == 3'd7, "R2 gap end", {outValid, outEop, outType}, 5'b11111);

    // R1 reset mid-packet, then a fresh keep-alive
    step(1'b1, 8'h01);
    step(1'b1, 8'h03);
    rst = 1'b1;
    step(1'b0, 8'h00);
    check({outValid, outSop, outEop, badPkt} == 4'b0, "R1 mid-packet reset",
          {outValid, outSop, outEop, badPkt}, 0);
    rst = 1'b0;
    step(1'b1, 8'h07);
    check(outValid && outSop && outType == 3'd7, "R1 resync type byte", {outValid, outSop}, 2'b11);
    step(1'b1, 8'h00); step(1'b1, 8'h55); step(1'b1, 8'h00);
    check(outValid && outEop, "R1 resync end", {outValid, outEop}, 2'b11);

    // R9 limit edges: total 4096 no flag, 4097 flags
    longAcl(4091, 1'b0);
    longAcl(4092, 1'b1);
    step(1'b1, 8'h07);
    check(outValid && outSop && outType == 3'd7, "R8 type after long packet",
          {outValid, outSop}, 2'b11);
    step(1'b1, 8'h00); step(1'b1, 8'h55); step(1'b1, 8'h00);
    step(1'b0, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule